// File: doc/BRIEF.md
# Per-Window Shadowed Configuration Registers

This block keeps the geometry and enable settings for a set of display overlay windows. Software writes a visible copy of each setting through a simple register bus and can read it back at once. Scanout logic never sees those writes directly. It uses a separate active copy, which is refreshed from the visible copy only in a cycle where the vertical sync pulse is high. A window whose protect bit is set skips that refresh. Software can therefore raise protect, rewrite start, end, position and size, then drop protect, and the whole group reaches scanout in one frame.

Each window has a small state machine with three states. SH_CLEAN means the active copy matches the visible copy. SH_PEND means there are unapplied writes and the window is unprotected. SH_HELD means there are unapplied writes and the window is protected. The transitions are as follows. A write to a window, or a change of its enable bit, moves it to SH_HELD if its next protect value is set and to SH_PEND otherwise. SH_PEND with vsync and no new write loads the active copy and moves to SH_CLEAN. SH_PEND moves to SH_HELD when protect is raised. SH_HELD moves to SH_PEND when protect is cleared. The bottom-right corner is derived from position and size when the active copy is loaded.

Top module: `shreg_bank`

## Requirements
- R1: After reset, every visible and active register is zero, including the enable, protect, position and size fields.
- R2: Register addresses use bits [4:2] as the window number (0 to 4) and bits [1:0] as the field: 0 is buffer start, 1 is buffer end, 2 is position (x in bits 11:0, y in bits 27:16) and 3 is size (width in bits 11:0, height in bits 27:16). A write updates the visible copy, and `rd_data` returns the visible copy in the same cycle. Any other address reads as zero.
- R3: A write never changes an active output by itself. At the end of a cycle where `vsync` is high, each unprotected window's active start, end and top-left take its visible values.
- R4: The control register is at address 28. Bits [4:0] are the per-window enables and bits [12:8] are the per-window protect bits. Protect takes effect immediately. While a window's protect bit is set, vsync leaves all of that window's active outputs unchanged.
- R5: After protect is cleared, the pending values of every register of that window move to the active copy together at the next vsync, and not before.
- R6: Enabling or disabling a window changes `act_en` only at a vsync.
- R7: The active bottom-right x equals (x + width - 1) modulo 4096, or 0 when x + width is 0. The same rule applies to y with height.
- R8: If a write and vsync occur in the same cycle, the active copy takes the value held before the write. The new value stays visible and is applied at the next unprotected vsync.
- R9: Protecting one window does not prevent the other windows from loading at vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Visible-copy read data (combinational) |
| vsync | input | 1 | Vertical sync pulse |
| act_start | output | 160 | Active buffer start, 32 bits per window |
| act_end | output | 160 | Active buffer end, 32 bits per window |
| act_tl_x | output | 60 | Active top-left x, 12 bits per window |
| act_tl_y | output | 60 | Active top-left y, 12 bits per window |
| act_br_x | output | 60 | Active bottom-right x, 12 bits per window |
| act_br_y | output | 60 | Active bottom-right y, 12 bits per window |
| act_en | output | 5 | Active enable status per window |

## Verification
The assertions check four things on every cycle. A window never sits in SH_PEND while it is protected. A protected window's active outputs stay frozen. Outside a vsync cycle, nothing active moves. A window in SH_CLEAN shows active values equal to its visible ones. Other behaviour depends on the order of events and only the bench scenarios can show it: the grouped release after protect is cleared, the old-value capture when a write lands on the vsync cycle, the clamp and wrap of the bottom-right corner, and one window loading while its neighbour is held. Those scenarios are also compared, cycle by cycle, against a behavioural model.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // Per-window shadow state
    typedef enum logic [1:0] {
        SH_CLEAN = 2'd0,
        SH_PEND  = 2'd1,
        SH_HELD  = 2'd2
    } sh_state_e;

    // Field selector codes inside a window's address slot
    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_END   = 2'd1;
    localparam logic [1:0] SEL_POS   = 2'd2;
    localparam logic [1:0] SEL_SIZE  = 2'd3;

    // Packing of the control word and the coordinate pairs
    localparam int PROT_LSB = 8;
    localparam int Y_LSB    = 16;

endpackage

// File: rtl/shreg_window.sv
module shreg_window
    import shreg_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync_i,
    input  logic          prot_i,
    input  logic          prot_nxt_i,
    input  logic          en_vis_i,
    input  logic          en_touch_i,
    input  logic          wr_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] vis_start_o,
    output logic [DW-1:0] vis_end_o,
    output logic [DW-1:0] vis_pos_o,
    output logic [DW-1:0] vis_size_o,
    output logic [DW-1:0] act_start_o,
    output logic [DW-1:0] act_end_o,
    output logic [CW-1:0] act_tlx_o,
    output logic [CW-1:0] act_tly_o,
    output logic [CW-1:0] act_brx_o,
    output logic [CW-1:0] act_bry_o,
    output logic          act_en_o
);

    sh_state_e st, st_nxt;

    logic          touched;
    logic          load;
    logic [CW:0]   sum_x, sum_y;
    logic [CW-1:0] brx_calc, bry_calc;

    assign touched = wr_i || en_touch_i;
    assign load    = vsync_i && (st == SH_PEND);

    // Derived corner from the visible copy, captured at load
    assign sum_x    = {1'b0, vis_pos_o[CW-1:0]} + {1'b0, vis_size_o[CW-1:0]};
    assign sum_y    = {1'b0, vis_pos_o[Y_LSB +: CW]} + {1'b0, vis_size_o[Y_LSB +: CW]};
    assign brx_calc = (sum_x == '0) ? '0 : CW'(sum_x - 1'b1);
    assign bry_calc = (sum_y == '0) ? '0 : CW'(sum_y - 1'b1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SH_CLEAN;
        else        st <= st_nxt;
    end

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            SH_CLEAN: begin
                if (touched) st_nxt = prot_nxt_i ? SH_HELD : SH_PEND;
            end
            SH_PEND: begin
                if (touched)         st_nxt = prot_nxt_i ? SH_HELD : SH_PEND;
                else if (load)       st_nxt = SH_CLEAN;
                else if (prot_nxt_i) st_nxt = SH_HELD;
            end
            SH_HELD: begin
                if (!prot_nxt_i) st_nxt = SH_PEND;
            end
            default: st_nxt = SH_CLEAN;
        endcase
    end

    // Visible and active register copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_start_o <= '0;
            vis_end_o   <= '0;
            vis_pos_o   <= '0;
            vis_size_o  <= '0;
            act_start_o <= '0;
            act_end_o   <= '0;
            act_tlx_o   <= '0;
            act_tly_o   <= '0;
            act_brx_o   <= '0;
            act_bry_o   <= '0;
            act_en_o    <= 1'b0;
        end else begin
            if (load) begin
                act_start_o <= vis_start_o;
                act_end_o   <= vis_end_o;
                act_tlx_o   <= vis_pos_o[CW-1:0];
                act_tly_o   <= vis_pos_o[Y_LSB +: CW];
                act_brx_o   <= brx_calc;
                act_bry_o   <= bry_calc;
                act_en_o    <= en_vis_i;
            end
            if (wr_i) begin
                unique case (wr_sel_i)
                    SEL_START: vis_start_o <= wr_data_i;
                    SEL_END:   vis_end_o   <= wr_data_i;
                    SEL_POS:   vis_pos_o   <= wr_data_i;
                    SEL_SIZE:  vis_size_o  <= wr_data_i;
                    default:   vis_start_o <= vis_start_o;
                endcase
            end
        end
    end

    AST_PEND_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_PEND) |-> !prot_i); // R4

    AST_PROT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_i |=> ($stable(act_start_o) && $stable(act_brx_o) && $stable(act_en_o))); // R4

    AST_NO_VSYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_i |=> ($stable(act_start_o) && $stable(act_end_o) && $stable(act_en_o))); // R3

    AST_CLEAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_CLEAN) |-> (act_start_o == vis_start_o && act_en_o == en_vis_i)); // R5

endmodule

// File: rtl/shreg_rdmux.sv
module shreg_rdmux
    import shreg_pkg::*;
#(
    parameter int NW     = 5,
    parameter int DW     = 32,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NW*DW-1:0]  vis_start,
    input  logic [NW*DW-1:0]  vis_end,
    input  logic [NW*DW-1:0]  vis_pos,
    input  logic [NW*DW-1:0]  vis_size,
    input  logic [DW-1:0]     ctrl_word,
    output logic [DW-1:0]     rd_data
);

    localparam int WF_W = ADDR_W - 2;
    localparam logic [WF_W-1:0] CTRL_WIN = '1;

    logic [WF_W-1:0] rd_win;
    logic [1:0]      rd_sel;

    assign rd_win = rd_addr[ADDR_W-1:2];
    assign rd_sel = rd_addr[1:0];

    always_comb begin
        rd_data = '0;
        if (rd_win == CTRL_WIN) begin
            if (rd_sel == 2'd0) rd_data = ctrl_word;
        end else begin
            for (int w = 0; w < NW; w++) begin
                if (rd_win == WF_W'(w)) begin
                    case (rd_sel)
                        SEL_START: rd_data = vis_start[w*DW +: DW];
                        SEL_END:   rd_data = vis_end[w*DW +: DW];
                        SEL_POS:   rd_data = vis_pos[w*DW +: DW];
                        default:   rd_data = vis_size[w*DW +: DW];
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
    import shreg_pkg::*;
#(
    parameter int NW     = 5,
    parameter int DW     = 32,
    parameter int CW     = 12,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              vsync,
    output logic [NW*DW-1:0]  act_start,
    output logic [NW*DW-1:0]  act_end,
    output logic [NW*CW-1:0]  act_tl_x,
    output logic [NW*CW-1:0]  act_tl_y,
    output logic [NW*CW-1:0]  act_br_x,
    output logic [NW*CW-1:0]  act_br_y,
    output logic [NW-1:0]     act_en
);

    localparam int WF_W = ADDR_W - 2;
    localparam logic [WF_W-1:0] CTRL_WIN = '1;

    logic [NW-1:0]    en_vis, prot, prot_nxt, en_touch;
    logic             ctrl_wr;
    logic [WF_W-1:0]  wr_win;
    logic [DW-1:0]    ctrl_word;
    logic [NW*DW-1:0] vis_start, vis_end, vis_pos, vis_size;

    assign wr_win   = wr_addr[ADDR_W-1:2];
    assign ctrl_wr  = wr_en && (wr_win == CTRL_WIN) && (wr_addr[1:0] == 2'd0);
    assign prot_nxt = ctrl_wr ? wr_data[PROT_LSB +: NW] : prot;
    assign en_touch = ctrl_wr ? (wr_data[NW-1:0] ^ en_vis) : '0;

    // Shared control register: enables are shadowed, protect is immediate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_vis <= '0;
            prot   <= '0;
        end else if (ctrl_wr) begin
            en_vis <= wr_data[NW-1:0];
            prot   <= wr_data[PROT_LSB +: NW];
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[NW-1:0]        = en_vis;
        ctrl_word[PROT_LSB +: NW] = prot;
    end

    for (genvar w = 0; w < NW; w++) begin : g_win
        logic win_wr;
        assign win_wr = wr_en && (wr_win == WF_W'(w));

        shreg_window #(.DW(DW), .CW(CW)) u_win (
            .clk         (clk),
            .rst_n       (rst_n),
            .vsync_i     (vsync),
            .prot_i      (prot[w]),
            .prot_nxt_i  (prot_nxt[w]),
            .en_vis_i    (en_vis[w]),
            .en_touch_i  (en_touch[w]),
            .wr_i        (win_wr),
            .wr_sel_i    (wr_addr[1:0]),
            .wr_data_i   (wr_data),
            .vis_start_o (vis_start[w*DW +: DW]),
            .vis_end_o   (vis_end[w*DW +: DW]),
            .vis_pos_o   (vis_pos[w*DW +: DW]),
            .vis_size_o  (vis_size[w*DW +: DW]),
            .act_start_o (act_start[w*DW +: DW]),
            .act_end_o   (act_end[w*DW +: DW]),
            .act_tlx_o   (act_tl_x[w*CW +: CW]),
            .act_tly_o   (act_tl_y[w*CW +: CW]),
            .act_brx_o   (act_br_x[w*CW +: CW]),
            .act_bry_o   (act_br_y[w*CW +: CW]),
            .act_en_o    (act_en[w])
        );
    end

    shreg_rdmux #(.NW(NW), .DW(DW), .ADDR_W(ADDR_W)) u_rd (
        .rd_addr   (rd_addr),
        .vis_start (vis_start),
        .vis_end   (vis_end),
        .vis_pos   (vis_pos),
        .vis_size  (vis_size),
        .ctrl_word (ctrl_word),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/sim_shreg_bank.sv
module sim_shreg_bank;

    localparam int NW = 5;
    localparam int DW = 32;
    localparam int CW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [4:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              vsync = 1'b0;
    logic [NW*DW-1:0]  act_start, act_end;
    logic [NW*CW-1:0]  act_tl_x, act_tl_y, act_br_x, act_br_y;
    logic [NW-1:0]     act_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    shreg_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .vsync(vsync), .act_start(act_start), .act_end(act_end),
        .act_tl_x(act_tl_x), .act_tl_y(act_tl_y), .act_br_x(act_br_x),
        .act_br_y(act_br_y), .act_en(act_en)
    );

    // Behavioural reference model
    int m_vs[NW], m_ve[NW], m_vp[NW], m_vz[NW];
    int m_as[NW], m_ae[NW], m_tx[NW], m_ty[NW], m_bx[NW], m_by[NW];
    bit m_ven[NW], m_aen[NW], m_prot[NW];

    function automatic int corner(input int p, input int s);
        int t;
        t = (p & 4095) + (s & 4095);
        return (t == 0) ? 0 : ((t - 1) & 4095);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_vs[w] = 0; m_ve[w] = 0; m_vp[w] = 0; m_vz[w] = 0;
                m_as[w] = 0; m_ae[w] = 0; m_tx[w] = 0; m_ty[w] = 0;
                m_bx[w] = 0; m_by[w] = 0;
                m_ven[w] = 0; m_aen[w] = 0; m_prot[w] = 0;
            end
        end else begin
            if (vsync) begin
                for (int w = 0; w < NW; w++) begin
                    if (!m_prot[w]) begin
                        m_as[w] = m_vs[w]; m_ae[w] = m_ve[w];
                        m_tx[w] = m_vp[w] & 4095;
                        m_ty[w] = (m_vp[w] >> 16) & 4095;
                        m_bx[w] = corner(m_vp[w], m_vz[w]);
                        m_by[w] = corner(m_vp[w] >> 16, m_vz[w] >> 16);
                        m_aen[w] = m_ven[w];
                    end
                end
            end
            if (wr_en) begin
                if (wr_addr == 5'd28) begin
                    for (int w = 0; w < NW; w++) begin
                        m_ven[w]  = wr_data[w];
                        m_prot[w] = wr_data[8 + w];
                    end
                end else if (wr_addr[4:2] < NW) begin
                    case (wr_addr[1:0])
                        2'd0: m_vs[wr_addr[4:2]] = wr_data;
                        2'd1: m_ve[wr_addr[4:2]] = wr_data;
                        2'd2: m_vp[wr_addr[4:2]] = wr_data;
                        default: m_vz[wr_addr[4:2]] = wr_data;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model every clock
    always @(negedge clk) begin
        if (rst_n) begin
            for (int w = 0; w < NW; w++) begin
                chk("R3 act_start", act_start[w*DW +: DW], 32'(m_as[w]));
                chk("R3 act_end",   act_end[w*DW +: DW],   32'(m_ae[w]));
                chk("R3 act_tl_x",  32'(act_tl_x[w*CW +: CW]), 32'(m_tx[w]));
                chk("R3 act_tl_y",  32'(act_tl_y[w*CW +: CW]), 32'(m_ty[w]));
                chk("R7 act_br_x",  32'(act_br_x[w*CW +: CW]), 32'(m_bx[w]));
                chk("R7 act_br_y",  32'(act_br_y[w*CW +: CW]), 32'(m_by[w]));
                chk("R6 act_en",    32'(act_en[w]), 32'(m_aen[w]));
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic vs);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; vsync = vs;
        @(negedge clk);
        wr_en = 1'b0; vsync = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 act_en", 32'(act_en), 32'h0);
        chk("R1 act_start0", act_start[31:0], 32'h0);
        rd(5'd0, 32'h0, "R1 read start0");
        rd(5'd28, 32'h0, "R1 read ctrl");

        // R2/R3/R7 window 0 programming
        wr(5'd0, 32'h0000_1000, 1'b0);
        wr(5'd1, 32'h0000_1FFF, 1'b0);
        wr(5'd2, 32'h0014_000A, 1'b0);
        wr(5'd3, 32'h0032_0064, 1'b0);
        #1;
        rd(5'd0, 32'h0000_1000, "R2 read start0");
        rd(5'd3, 32'h0032_0064, "R2 read size0");
        rd(5'd20, 32'h0, "R2 unmapped read");
        chk("R3 no vsync yet", act_start[31:0], 32'h0);
        pulse();
        #1;
        chk("R3 start0 loaded", act_start[31:0], 32'h0000_1000);
        chk("R7 br_x0", 32'(act_br_x[11:0]), 32'd109);
        chk("R7 br_y0", 32'(act_br_y[11:0]), 32'd69);

        // R6 enable is shadowed
        wr(5'd28, 32'h0000_0001, 1'b0);
        #1;
        chk("R6 enable waits", 32'(act_en), 32'h0);
        pulse();
        #1;
        chk("R6 enable applied", 32'(act_en), 32'h1);

        // R4/R5/R9 protect window 1, window 2 loads freely
        wr(5'd28, 32'h0000_0201, 1'b0);
        rd(5'd28, 32'h0000_0201, "R4 read ctrl");
        wr(5'd4, 32'h0000_3000, 1'b0);
        wr(5'd6, 32'h0005_0005, 1'b0);
        wr(5'd7, 32'h0003_0002, 1'b0);
        wr(5'd8, 32'h0000_4000, 1'b0);
        pulse();
        #1;
        chk("R4 held start1", act_start[63:32], 32'h0);
        chk("R9 free start2", act_start[95:64], 32'h0000_4000);
        wr(5'd28, 32'h0000_0001, 1'b0);
        #1;
        chk("R5 no vsync after release", act_start[63:32], 32'h0);
        pulse();
        #1;
        chk("R5 start1 released", act_start[63:32], 32'h0000_3000);
        chk("R5 br_x1", 32'(act_br_x[23:12]), 32'd6);
        chk("R5 br_y1", 32'(act_br_y[23:12]), 32'd7);

        // R7 clamp and wrap on window 3
        wr(5'd14, 32'h0000_0FFF, 1'b0);
        wr(5'd15, 32'h0000_0001, 1'b0);
        pulse();
        #1;
        chk("R7 br_x3 wrap", 32'(act_br_x[47:36]), 32'd4095);
        chk("R7 br_y3 clamp", 32'(act_br_y[47:36]), 32'd0);

        // R8 write in the vsync cycle
        wr(5'd0, 32'h0000_2000, 1'b1);
        #1;
        chk("R8 old value active", act_start[31:0], 32'h0000_1000);
        rd(5'd0, 32'h0000_2000, "R8 new value visible");
        pulse();
        #1;
        chk("R8 new value applied", act_start[31:0], 32'h0000_2000);

        // R6 disable is shadowed
        wr(5'd28, 32'h0000_0000, 1'b0);
        #1;
        chk("R6 disable waits", 32'(act_en), 32'h1);
        pulse();
        #1;
        chk("R6 disable applied", 32'(act_en), 32'h0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule